// File: doc/BRIEF.md
# Write-Protect and ID Unlock Controller

This block sits behind a serial command decoder and decides, one command at a time, whether a write to a nonvolatile array or to a small protected ID area may go ahead. The decoder hands it a strobe with the opcode, a strobe for each later byte, and a strobe when chip select returns high. That last strobe comes with a flag that says the final byte was cut short. The block keeps a write-enable flag, a two-bit protection level and a busy flag. It presents all three as a status byte. It also tracks the multi-command ritual that opens the ID area.

When a command ends cleanly and is permitted, the block issues a one-cycle write-start pulse. The pulse carries a target (array, ID area or status), a start address and a data-byte count. A programming engine outside this block then reports completion on a done strobe. The block also gives a 16-entry ID pointer that steps with each clocked byte, so read and write data can be routed to the right ID location.

Top module: `nv_write_guard`

## Requirements
- R1: The status byte is {4'b0000, prot[1], prot[0], enable, busy}, with enable at bit 1 and busy at bit 0. After reset it reads 0x00.
- R2: Only a completed enable command sets the enable flag. A completed disable command clears it. No other command raises it.
- R3: The enable flag is cleared in the same cycle that any array, ID or status write starts.
- R4: An array write is refused when its start address lies in the protected zone. Protection level 1 covers 0xC0 to 0xFF, level 2 covers 0x80 to 0xFF, level 3 covers every address, and level 0 covers none.
- R5: A write starts only at a chip-select rise whose last byte was whole. An array or ID write needs an address byte followed by 1 to 8 data bytes. A status write needs exactly one data byte. A longer or shorter command starts nothing. The start pulse lasts one cycle and comes with target code (0 array, 1 ID, 2 status), start address and data-byte count.
- R6: A write start sets busy, and the done strobe clears it. While busy is set, every command except a status read is ignored.
- R7: The ID area opens only after three separate commands in this order: a completed enable, then an unlock command with data 0x55, then an unlock command with data 0xAA. Any other completed command in between resets the sequence.
- R8: Once the ID area is open, the very next command must be an ID write. Any other command closes the area again and clears the enable flag.
- R9: The ID pointer loads the low four bits of the first byte after the opcode. It then advances by one on each further byte, wrapping from 0xF to 0x0. An ID write uses those low four bits as its start address.
- R10: An ID write is not refused because of the protection level.
- R11: A status write copies bits 3:2 of its data byte into the protection level. The new level shows in the status byte in the same cycle as the start pulse.
- R12: An opcode that matches no known command resets a partly completed unlock sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Opcode byte strobe, starts a new command |
| cmdOp | input | 8 | Opcode value |
| byteValid | input | 1 | Strobe for each byte after the opcode |
| byteData | input | 8 | Byte value (address or data) |
| csRise | input | 1 | Chip select returned high, command ends |
| partialByte | input | 1 | With csRise: the last byte was not whole |
| wrDone | input | 1 | Programming engine finished the current write |
| statusByte | output | 8 | Status: protection level, enable, busy |
| idPtr | output | ID_AW | Current ID-area location |
| wrStart | output | 1 | One-cycle write start |
| wrTarget | output | 2 | 0 array, 1 ID area, 2 status |
| wrAddr | output | 8 | Start address of the write |
| wrLen | output | $clog2(MAX_BURST+1) | Number of data bytes in the write |

## Verification
A wrong enable flag, busy flag or protection level shows on the status byte one cycle after the chip-select rise that caused it, so the bench compares that byte on every clock. A wrong unlock stage has no port of its own. It surfaces only when the next ID write starts or fails to start, one cycle after that command ends. That is why the bench follows each broken or reordered unlock sequence with an ID write attempt. A wrong protection decision or burst-length check shows as a start pulse that is present or missing, with its target, address and count, one cycle after chip select rises.

// File: rtl/guard_pkg.sv
package guard_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TGT_ARRAY  = 2'd0,
    TGT_ID     = 2'd1,
    TGT_STATUS = 2'd2
  } wr_target_e;

  typedef enum logic [1:0] {
    UL_NONE,
    UL_ENABLED,
    UL_FIRST,
    UL_OPEN
  } unlock_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic       setEn;
    logic       clrEn;
    logic       start;
    logic       loadProt;
    wr_target_e target;
  } guard_strobe_t;

  // protected zone keyed on the two top address bits
  function automatic logic inProtectedZone(input logic [1:0] prot, input logic [1:0] top);
    case (prot)
      2'b00:   return 1'b0;
      2'b01:   return top == 2'b11;
      2'b10:   return top[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int ID_AW = 4,
  parameter int MAX_BURST = 8,
  localparam int CNT_W = $clog2(MAX_BURST + 3),
  localparam int LEN_W = $clog2(MAX_BURST + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [BYTE_W-1:0]   cmdOp,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  input  logic                csRise,
  input  logic                wrDone,
  input  guard_strobe_t       strobe,
  output logic [BYTE_W-1:0]   opReg,
  output logic [CNT_W-1:0]    byteCnt,
  output logic [BYTE_W-1:0]   firstByte,
  output logic                cmdSeen,
  output logic                writeEn,
  output logic                busy,
  output logic [1:0]          protLvl,
  output logic [ID_AW-1:0]    idPtr,
  output logic                wrStart,
  output wr_target_e          wrTarget,
  output logic [BYTE_W-1:0]   wrAddr,
  output logic [LEN_W-1:0]    wrLen
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BURST + 2);

  // command capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg     <= '0;
      byteCnt   <= '0;
      firstByte <= '0;
      cmdSeen   <= 1'b0;
      idPtr     <= '0;
    end else begin
      if (cmdValid) begin
        opReg   <= cmdOp;
        byteCnt <= '0;
        cmdSeen <= 1'b1;
      end else begin
        if (byteValid) begin
          if (byteCnt == '0) begin
            firstByte <= byteData;
            idPtr     <= byteData[ID_AW-1:0];
          end else begin
            idPtr <= idPtr + 1'b1;
          end
          if (byteCnt != CNT_SAT) byteCnt <= byteCnt + 1'b1;
        end
        if (csRise) cmdSeen <= 1'b0;
      end
    end
  end

  // guarded state and write launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeEn  <= 1'b0;
      busy     <= 1'b0;
      protLvl  <= 2'b00;
      wrStart  <= 1'b0;
      wrTarget <= TGT_ARRAY;
      wrAddr   <= '0;
      wrLen    <= '0;
    end else begin
      wrStart <= strobe.start;
      if (strobe.setEn)      writeEn <= 1'b1;
      else if (strobe.clrEn) writeEn <= 1'b0;
      if (strobe.start)      busy <= 1'b1;
      else if (wrDone)       busy <= 1'b0;
      if (strobe.loadProt)   protLvl <= firstByte[3:2];
      if (strobe.start) begin
        wrTarget <= strobe.target;
        case (strobe.target)
          TGT_ID: begin
            wrAddr <= BYTE_W'(firstByte[ID_AW-1:0]);
            wrLen  <= LEN_W'(byteCnt - 1'b1);
          end
          TGT_STATUS: begin
            wrAddr <= '0;
            wrLen  <= LEN_W'(1);
          end
          default: begin
            wrAddr <= firstByte;
            wrLen  <= LEN_W'(byteCnt - 1'b1);
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/guard_control.sv
module guard_control
  import guard_pkg::*;
#(
  parameter int MAX_BURST = 8,
  parameter logic [7:0] OP_ENABLE  = 8'h06,
  parameter logic [7:0] OP_DISABLE = 8'h04,
  parameter logic [7:0] OP_STAT_RD = 8'h05,
  parameter logic [7:0] OP_STAT_WR = 8'h01,
  parameter logic [7:0] OP_MEM_WR  = 8'h02,
  parameter logic [7:0] OP_KEY     = 8'h14,
  parameter logic [7:0] OP_UID_WR  = 8'h32,
  parameter logic [7:0] KEY_ONE    = 8'h55,
  parameter logic [7:0] KEY_TWO    = 8'hAA,
  localparam int CNT_W = $clog2(MAX_BURST + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csRise,
  input  logic              partialByte,
  input  logic [BYTE_W-1:0] opReg,
  input  logic [CNT_W-1:0]  byteCnt,
  input  logic [BYTE_W-1:0] firstByte,
  input  logic              cmdSeen,
  input  logic              writeEn,
  input  logic              busy,
  input  logic [1:0]        protLvl,
  output guard_strobe_t     strobe
);

  unlock_e stage, stageNext;
  logic cmdEnd, burstOk, oneByte, blocked;

  always_comb begin
    strobe    = '0;
    stageNext = stage;
    cmdEnd    = csRise && cmdSeen;
    burstOk   = (byteCnt >= CNT_W'(2)) && (byteCnt <= CNT_W'(MAX_BURST + 1));
    oneByte   = byteCnt == CNT_W'(1);
    blocked   = busy && (opReg != OP_STAT_RD);
    if (cmdEnd && !blocked) begin
      stageNext    = UL_NONE;
      strobe.clrEn = (stage == UL_OPEN);
      if (!partialByte) begin
        if (opReg == OP_ENABLE) begin
          strobe.setEn = 1'b1;
          stageNext    = UL_ENABLED;
        end else if (opReg == OP_DISABLE) begin
          strobe.clrEn = 1'b1;
        end else if (opReg == OP_STAT_WR) begin
          if (oneByte && writeEn) begin
            strobe.start    = 1'b1;
            strobe.loadProt = 1'b1;
            strobe.target   = TGT_STATUS;
          end
        end else if (opReg == OP_MEM_WR) begin
          if (burstOk && writeEn && !inProtectedZone(protLvl, firstByte[BYTE_W-1 -: 2])) begin
            strobe.start  = 1'b1;
            strobe.target = TGT_ARRAY;
          end
        end else if (opReg == OP_UID_WR) begin
          if (burstOk && stage == UL_OPEN) begin
            strobe.start  = 1'b1;
            strobe.target = TGT_ID;
          end
        end else if (opReg == OP_KEY && oneByte) begin
          if (stage == UL_ENABLED && firstByte == KEY_ONE)   stageNext = UL_FIRST;
          else if (stage == UL_FIRST && firstByte == KEY_TWO) stageNext = UL_OPEN;
        end
      end
      if (strobe.start) strobe.clrEn = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= UL_NONE;
    else       stage <= stageNext;
  end

endmodule

// File: rtl/nv_write_guard.sv
module nv_write_guard
  import guard_pkg::*;
#(
  parameter int ID_AW = 4,
  parameter int MAX_BURST = 8,
  parameter logic [7:0] OP_ENABLE  = 8'h06,
  parameter logic [7:0] OP_DISABLE = 8'h04,
  parameter logic [7:0] OP_STAT_RD = 8'h05,
  parameter logic [7:0] OP_STAT_WR = 8'h01,
  parameter logic [7:0] OP_MEM_WR  = 8'h02,
  parameter logic [7:0] OP_KEY     = 8'h14,
  parameter logic [7:0] OP_UID_WR  = 8'h32,
  parameter logic [7:0] KEY_ONE    = 8'h55,
  parameter logic [7:0] KEY_TWO    = 8'hAA
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cmdValid,
  input  logic [7:0]                       cmdOp,
  input  logic                             byteValid,
  input  logic [7:0]                       byteData,
  input  logic                             csRise,
  input  logic                             partialByte,
  input  logic                             wrDone,
  output logic [7:0]                       statusByte,
  output logic [ID_AW-1:0]                 idPtr,
  output logic                             wrStart,
  output logic [1:0]                       wrTarget,
  output logic [7:0]                       wrAddr,
  output logic [$clog2(MAX_BURST+1)-1:0]   wrLen
);

  localparam int CNT_W = $clog2(MAX_BURST + 3);

  guard_strobe_t      strobe;
  logic [BYTE_W-1:0]  opReg, firstByte;
  logic [CNT_W-1:0]   byteCnt;
  logic               cmdSeen, writeEn, busy;
  logic [1:0]         protLvl;
  wr_target_e         tgt;

  guard_control #(
    .MAX_BURST(MAX_BURST), .OP_ENABLE(OP_ENABLE), .OP_DISABLE(OP_DISABLE),
    .OP_STAT_RD(OP_STAT_RD), .OP_STAT_WR(OP_STAT_WR), .OP_MEM_WR(OP_MEM_WR),
    .OP_KEY(OP_KEY), .OP_UID_WR(OP_UID_WR), .KEY_ONE(KEY_ONE), .KEY_TWO(KEY_TWO)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csRise(csRise), .partialByte(partialByte),
    .opReg(opReg), .byteCnt(byteCnt), .firstByte(firstByte), .cmdSeen(cmdSeen),
    .writeEn(writeEn), .busy(busy), .protLvl(protLvl), .strobe(strobe)
  );

  guard_datapath #(.ID_AW(ID_AW), .MAX_BURST(MAX_BURST)) i_dp (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise), .wrDone(wrDone),
    .strobe(strobe), .opReg(opReg), .byteCnt(byteCnt), .firstByte(firstByte),
    .cmdSeen(cmdSeen), .writeEn(writeEn), .busy(busy), .protLvl(protLvl),
    .idPtr(idPtr), .wrStart(wrStart), .wrTarget(tgt), .wrAddr(wrAddr), .wrLen(wrLen)
  );

  assign wrTarget   = tgt;
  assign statusByte = {{(BYTE_W-4){1'b0}}, protLvl, writeEn, busy};

endmodule

// File: rtl/nv_write_guard_chk.sv
module nv_write_guard_chk
  import guard_pkg::*;
#(
  parameter int MAX_BURST = 8
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             csRise,
  input logic                             partialByte,
  input logic [7:0]                       statusByte,
  input logic                             wrStart,
  input logic [1:0]                       wrTarget,
  input logic [7:0]                       wrAddr,
  input logic [$clog2(MAX_BURST+1)-1:0]   wrLen
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> !wrStart); // R5
  AST_START_AT_CS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> ($past(csRise) && !$past(partialByte))); // R5
  AST_START_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> (wrLen >= 1 && wrLen <= MAX_BURST)); // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> statusByte[0]); // R6
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> !$past(statusByte[0])); // R6
  AST_START_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> !statusByte[1]); // R3
  AST_ENABLE_RISE_AT_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[1]) |-> $past(csRise)); // R2
  AST_ARRAY_OUTSIDE_ZONE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStart && wrTarget == 2'd0) |-> !inProtectedZone($past(statusByte[3:2]), wrAddr[7:6])); // R4
  AST_PROT_ONLY_BY_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] != $past(statusByte[3:2])) |-> (wrStart && wrTarget == 2'd2)); // R11

endmodule

bind nv_write_guard nv_write_guard_chk #(.MAX_BURST(MAX_BURST)) i_chk (
  .clk(clk), .rstN(rstN), .csRise(csRise), .partialByte(partialByte),
  .statusByte(statusByte), .wrStart(wrStart), .wrTarget(wrTarget),
  .wrAddr(wrAddr), .wrLen(wrLen)
);

// File: tb/test_nv_write_guard.sv
module test_nv_write_guard;

  localparam logic [7:0] OP_ENABLE  = 8'h06;
  localparam logic [7:0] OP_DISABLE = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;
  localparam logic [7:0] OP_KEY     = 8'h14;
  localparam logic [7:0] OP_UID_WR  = 8'h32;
  localparam logic [7:0] OP_UID_RD  = 8'h33;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, byteValid = 1'b0, csRise = 1'b0, partialByte = 1'b0, wrDone = 1'b0;
  logic [7:0] cmdOp = '0, byteData = '0;
  logic [7:0] statusByte, wrAddr;
  logic [3:0] idPtr, wrLen;
  logic [1:0] wrTarget;
  logic wrStart;

  always #4 clk = ~clk;

  nv_write_guard i_nv_write_guard (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .partialByte(partialByte), .wrDone(wrDone), .statusByte(statusByte),
    .idPtr(idPtr), .wrStart(wrStart), .wrTarget(wrTarget), .wrAddr(wrAddr), .wrLen(wrLen)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mEn, mBusy, mProt, mStage, mPtr, mStart, mTgt, mAddr, mLen;
  bit mHave;
  logic [7:0] mOp;
  int mQ[$];

  function automatic bit zoneHit(input int prot, input int addr);
    if (prot == 3) return 1;
    if (prot == 2) return addr >= 'h80;
    if (prot == 1) return addr >= 'hC0;
    return 0;
  endfunction

  task automatic launch(input int tgt, input int addr, input int len);
    mStart = 1; mBusy = 1; mEn = 0; mTgt = tgt; mAddr = addr; mLen = len;
  endtask

  task automatic modelEnd();
    int n = mQ.size();
    int f = (n > 0) ? mQ[0] : 0;
    int was = mStage;
    if (mBusy != 0 && mOp != OP_STAT_RD) return;
    mStage = 0;
    if (was == 3) mEn = 0;
    if (partialByte) return;
    if (mOp == OP_ENABLE) begin mEn = 1; mStage = 1; end
    else if (mOp == OP_DISABLE) mEn = 0;
    else if (mOp == OP_STAT_WR) begin
      if (n == 1 && mEn != 0) begin launch(2, 0, 1); mProt = (f >> 2) & 3; end
    end else if (mOp == OP_MEM_WR) begin
      if (n >= 2 && n <= 9 && mEn != 0 && !zoneHit(mProt, f)) launch(0, f, n - 1);
    end else if (mOp == OP_UID_WR) begin
      if (n >= 2 && n <= 9 && was == 3) launch(1, f % 16, n - 1);
    end else if (mOp == OP_KEY && n == 1) begin
      if (was == 1 && f == 'h55) mStage = 2;
      else if (was == 2 && f == 'hAA) mStage = 3;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mBusy = 0; mProt = 0; mStage = 0; mPtr = 0; mStart = 0;
      mTgt = 0; mAddr = 0; mLen = 0; mHave = 0; mOp = '0; mQ.delete();
    end else begin
      mStart = 0;
      if (cmdValid) begin mOp = cmdOp; mQ.delete(); mHave = 1; end
      else if (byteValid) begin
        if (mQ.size() == 0) mPtr = byteData % 16;
        else mPtr = (mPtr + 1) % 16;
        mQ.push_back(byteData);
      end
      if (csRise && mHave && !cmdValid) begin modelEnd(); mHave = 0; end
      if (wrDone && mStart == 0) mBusy = 0;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1", statusByte, (mProt << 2) | (mEn << 1) | mBusy, "status byte");
      check("R5", wrStart, mStart, "start pulse");
      check("R9", idPtr, mPtr, "ID pointer");
      if (mStart != 0) begin
        check("R5", wrTarget, mTgt, "start target");
        check("R5", wrAddr, mAddr, "start address");
        check("R5", wrLen, mLen, "start length");
      end
    end
  end

  int startCnt = 0;
  always @(negedge clk) if (rstN && wrStart) startCnt++;

  // ---------------- stimulus ----------------
  logic [7:0] txq[$];

  task automatic runCmd(input logic [7:0] op, input bit partial);
    @(negedge clk); cmdValid = 1'b1; cmdOp = op;
    @(negedge clk); cmdValid = 1'b0;
    for (int i = 0; i < txq.size(); i++) begin
      byteValid = 1'b1; byteData = txq[i];
      @(negedge clk); byteValid = 1'b0;
    end
    csRise = 1'b1; partialByte = partial;
    @(negedge clk); csRise = 1'b0; partialByte = 1'b0;
    @(negedge clk);
    txq.delete();
  endtask

  task automatic cmd0(input logic [7:0] op);
    runCmd(op, 1'b0);
  endtask

  task automatic cmd1(input logic [7:0] op, input logic [7:0] b);
    txq.push_back(b);
    runCmd(op, 1'b0);
  endtask

  task automatic cmdN(input logic [7:0] op, input logic [7:0] first, input int n);
    txq.push_back(first);
    for (int i = 0; i < n; i++) txq.push_back(8'(i + 1));
    runCmd(op, 1'b0);
  endtask

  task automatic finishWrite();
    @(negedge clk); wrDone = 1'b1;
    @(negedge clk); wrDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int s;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", statusByte, 8'h00, "reset status");

    s = startCnt; cmdN(OP_MEM_WR, 8'h10, 1);
    check("R2", startCnt - s, 0, "array write without enable");
    cmd0(OP_ENABLE);  check("R2", statusByte, 8'h02, "enable sets flag");
    cmd0(OP_DISABLE); check("R2", statusByte, 8'h00, "disable clears flag");
    runCmd(OP_ENABLE, 1'b1);
    check("R5", statusByte, 8'h00, "cut-short enable ignored");

    cmd0(OP_ENABLE);
    s = startCnt; cmdN(OP_MEM_WR, 8'h10, 2);
    check("R5", startCnt - s, 1, "plain array write starts");
    check("R3", statusByte, 8'h01, "enable dropped and busy set");
    cmd0(OP_ENABLE);
    check("R6", statusByte, 8'h01, "enable ignored while busy");
    finishWrite();
    check("R6", statusByte, 8'h00, "done clears busy");

    cmd0(OP_ENABLE); cmd1(OP_STAT_WR, 8'h04);
    check("R11", statusByte, 8'h05, "new level visible at once");
    finishWrite();
    cmd0(OP_ENABLE);
    s = startCnt; cmdN(OP_MEM_WR, 8'hC0, 1);
    check("R4", startCnt - s, 0, "level 1 blocks C0");
    s = startCnt; cmdN(OP_MEM_WR, 8'hBF, 1);
    check("R4", startCnt - s, 1, "level 1 allows BF");
    finishWrite();

    cmd0(OP_ENABLE); cmd1(OP_STAT_WR, 8'h08); finishWrite();
    cmd0(OP_ENABLE);
    s = startCnt; cmdN(OP_MEM_WR, 8'h80, 1);
    check("R4", startCnt - s, 0, "level 2 blocks 80");
    s = startCnt; cmdN(OP_MEM_WR, 8'h7F, 1);
    check("R4", startCnt - s, 1, "level 2 allows 7F");
    finishWrite();

    cmd0(OP_ENABLE); cmd1(OP_STAT_WR, 8'h0C); finishWrite();
    check("R11", statusByte, 8'h0C, "level 3 stored");
    cmd0(OP_ENABLE);
    s = startCnt; cmdN(OP_MEM_WR, 8'h00, 1);
    check("R4", startCnt - s, 0, "level 3 blocks 00");

    cmd0(OP_ENABLE); cmd1(OP_KEY, 8'h55); cmd1(OP_KEY, 8'hAA);
    s = startCnt; cmdN(OP_UID_WR, 8'h1E, 3);
    check("R7", startCnt - s, 1, "ID write after full unlock");
    check("R10", statusByte, 8'h0D, "ID write despite level 3");
    check("R9", idPtr, 4'h1, "pointer wrapped past F");
    finishWrite();

    cmd0(OP_ENABLE); cmd1(OP_KEY, 8'h55); cmd0(OP_STAT_RD); cmd1(OP_KEY, 8'hAA);
    s = startCnt; cmdN(OP_UID_WR, 8'h00, 1);
    check("R7", startCnt - s, 0, "interrupted unlock");

    cmd0(OP_ENABLE); cmd1(OP_KEY, 8'h55); cmd1(OP_KEY, 8'hAA);
    cmdN(OP_MEM_RD, 8'h00, 1);
    check("R8", statusByte, 8'h0C, "other command relocks and drops enable");
    s = startCnt; cmdN(OP_UID_WR, 8'h00, 1);
    check("R8", startCnt - s, 0, "ID write after relock");

    cmd0(OP_ENABLE); cmd1(OP_KEY, 8'h55); cmd0(8'hA5); cmd1(OP_KEY, 8'hAA);
    s = startCnt; cmdN(OP_UID_WR, 8'h00, 1);
    check("R12", startCnt - s, 0, "unknown opcode aborts unlock");

    cmd0(OP_ENABLE); cmd1(OP_KEY, 8'h56); cmd1(OP_KEY, 8'hAA);
    s = startCnt; cmdN(OP_UID_WR, 8'h00, 1);
    check("R7", startCnt - s, 0, "wrong first key");

    cmd0(OP_ENABLE); cmd1(OP_STAT_WR, 8'h00); finishWrite();
    cmd0(OP_ENABLE);
    s = startCnt; cmdN(OP_MEM_WR, 8'h00, 9);
    check("R5", startCnt - s, 0, "nine data bytes refused");
    s = startCnt; cmdN(OP_MEM_WR, 8'h00, 8);
    check("R5", startCnt - s, 1, "eight data bytes accepted");
    cmd0(OP_STAT_RD);
    check("R6", statusByte, 8'h01, "status read while busy");
    finishWrite();

    cmdN(OP_UID_RD, 8'h1F, 2);
    check("R9", idPtr, 4'h1, "read pointer wraps");

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, all requirements unchecked");
    summary();
  end

endmodule